// File: doc/BRIEF.md
# TDM Time-Slot Router

This block sits between a TDM framer and a set of internal serial channels. The framer supplies a one-cycle bit tick, a frame-start marker and the received line bit. The router counts bit positions inside the frame, groups them into 8-bit slots and decides, slot by slot, which channel owns each slot. On the receive side, each bit of an owned slot goes to its channel with a one-hot strobe. On the transmit side, the line bit is taken from the owning channel. Slots that no channel owns produce no strobe on receive and a constant 1 on transmit.

Routing is not a per-slot lookup. Each direction holds an ordered list of runs, and each run gives a number of slots and the channel that owns them. The router walks this list as the slot counter advances. Each direction has two banks. Software writes a complete list into the staging bank and then requests a swap. The swap takes place only at the next frame start, so a frame already in progress always runs on a single table.

Top module: `tdm_slot_router`

## Requirements
- R1: After reset, `rx_ch_valid` and `tx_ch_take` are zero and `tx_bit` is 1. Until the first bit tick with `frame_sync` high, every bit is treated as unused.
- R2: A route entry has three fields: `cfg_count_m1` (the slot count minus one, so 1 to 64 slots), `cfg_dest` (3 bits) and `cfg_last` (this is the final run). The bit tick that carries `frame_sync` is bit 0 of slot 0. Runs apply in address order starting at entry 0, and each run uses up all of its slots before the next run starts.
- R3: A slot is SLOT_BITS bits (default 8). The slot number advances after every SLOT_BITS bit ticks, counting from the frame-sync bit.
- R4: Destination code k in 1..NUM_CH selects channel k-1. On the clock after a bit tick in a receive slot routed to code k, `rx_ch_valid` is exactly bit k-1 and `rx_ch_data` equals the sampled `rx_bit`. Codes 0 and any code above NUM_CH (6 and 7 by default) mean unused and give no strobe. No strobe appears on a cycle that does not follow a bit tick.
- R5: On the clock after a bit tick in a transmit slot routed to code k, `tx_bit` equals `ch_tx_data[k-1]` as sampled at that tick, and `tx_ch_take` is exactly bit k-1. In an unused slot, `tx_bit` is 1 and `tx_ch_take` is zero. Between bit ticks, `tx_bit` holds its value and `tx_ch_take` is zero.
- R6: Slots after the run marked last, or after entry MAX_ENTRIES-1 when no run is marked last, are unused until the next frame sync.
- R7: Receive and transmit tables are independent. `cfg_dir`=0 selects receive and 1 selects transmit, for both writes and commits.
- R8: Writes always go to the staging bank. A commit makes the staging bank active at the next frame-sync tick and not before. The active table, and therefore the frame in progress, is not affected by writes or commits.
- R9: A frame sync that arrives in the middle of a slot or a run restarts counting at bit 0 of slot 0, using entry 0.
- R10: A single run of 64 slots routes all 64 slots to its channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle tick, one per line bit |
| frame_sync | input | 1 | Qualified by bit_en; marks bit 0 of slot 0 |
| rx_bit | input | 1 | Received line bit, sampled on bit_en |
| rx_ch_data | output | 1 | Bit forwarded to the receive channels |
| rx_ch_valid | output | NUM_CH | One-hot strobe for the receiving channel |
| ch_tx_data | input | NUM_CH | Current transmit bit offered by each channel |
| tx_bit | output | 1 | Transmit line bit |
| tx_ch_take | output | NUM_CH | One-hot strobe: that channel's bit was sent |
| cfg_we | input | 1 | Route entry write strobe |
| cfg_dir | input | 1 | Table select: 0 receive, 1 transmit |
| cfg_addr | input | log2(MAX_ENTRIES) | Entry index |
| cfg_count_m1 | input | 6 | Run length minus one |
| cfg_dest | input | 3 | Destination code |
| cfg_last | input | 1 | Entry ends the list |
| cfg_commit | input | 1 | Request a bank swap at the next frame sync |

## Verification
Each receive and transmit result is registered once and is due on the first clock edge after the bit tick that produced it. The bench drives each tick at a falling edge and compares all four outputs at the next falling edge. On cycles without a tick, it confirms that strobes are low and `tx_bit` is unchanged. Bank swaps are due only at the frame-sync tick. The bench's own table model therefore switches tables at that tick, and the bits checked between a commit and the next frame sync are expected to follow the old table.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int DEST_W = 3;
  localparam int RUN_W  = 6;

  typedef struct packed {
    logic              last;
    logic [DEST_W-1:0] dest;
    logic [RUN_W-1:0]  run_m1;
  } route_t;

  localparam route_t ROUTE_IDLE = '{last: 1'b1, dest: '0, run_m1: '0};
endpackage

// File: rtl/tsr_route_ram.sv
module tsr_route_ram #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 10,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tsr_run_walker.sv
module tsr_run_walker
  import tsr_pkg::*;
#(
  parameter int SLOT_BITS   = 8,
  parameter int MAX_ENTRIES = 64,
  parameter int NUM_CH      = 5,
  localparam int IDX_W = $clog2(MAX_ENTRIES),
  localparam int BIT_W = $clog2(SLOT_BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              frame_sync,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  route_t            wr_data,
  input  logic              commit,
  output logic [DEST_W-1:0] dest
);
  localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(SLOT_BITS - 1);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(MAX_ENTRIES - 1);
  localparam logic [DEST_W-1:0] MAX_CODE = DEST_W'(NUM_CH);

  logic             act_bank, pend, in_frame, done, past_ok;
  logic [BIT_W-1:0] bit_cnt;
  logic [RUN_W-1:0] run_left;
  logic [IDX_W-1:0] idx, idx_nx;
  route_t           cur, nxt, head0, head1, head_new;
  logic             new_bank;
  logic [DEST_W-1:0] raw;

  assign idx_nx   = idx + 1'b1;
  assign new_bank = pend ? ~act_bank : act_bank;
  assign head_new = new_bank ? head1 : head0;

  // Staging bank is always the one not in use; reads follow the active bank.
  tsr_route_ram #(.DEPTH(2 * MAX_ENTRIES), .WIDTH($bits(route_t))) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr ({~act_bank, wr_addr}),
    .wdata (wr_data),
    .raddr ({act_bank, idx_nx}),
    .rdata (nxt)
  );

  // Entry 0 of each bank is mirrored so slot 0 needs no read latency.
  always_ff @(posedge clk) begin
    if (rst) begin
      head0 <= ROUTE_IDLE;
      head1 <= ROUTE_IDLE;
    end else if (wr_en && wr_addr == '0) begin
      if (act_bank) head0 <= wr_data;
      else          head1 <= wr_data;
    end
  end

  always_comb begin
    if (frame_sync)            raw = head_new.dest;
    else if (in_frame && !done) raw = cur.dest;
    else                        raw = '0;
    dest = (raw != '0 && raw <= MAX_CODE) ? raw : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_bank <= 1'b0;
      pend     <= 1'b0;
      in_frame <= 1'b0;
      done     <= 1'b0;
      bit_cnt  <= '0;
      run_left <= '0;
      idx      <= '0;
      cur      <= ROUTE_IDLE;
    end else begin
      if (commit) pend <= 1'b1;
      if (bit_en) begin
        if (frame_sync) begin
          act_bank <= new_bank;
          pend     <= commit;
          cur      <= head_new;
          run_left <= head_new.run_m1;
          bit_cnt  <= BIT_W'(1);
          idx      <= '0;
          done     <= 1'b0;
          in_frame <= 1'b1;
        end else if (in_frame && !done) begin
          if (bit_cnt == LAST_BIT) begin
            bit_cnt <= '0;
            if (run_left == '0) begin
              if (cur.last || idx == LAST_IDX) begin
                done <= 1'b1;
              end else begin
                cur      <= nxt;
                run_left <= nxt.run_m1;
                idx      <= idx_nx;
              end
            end else begin
              run_left <= run_left - 1'b1;
            end
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assert_walk_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(bit_en)) |-> ($stable(cur) && $stable(idx) && $stable(run_left)));

  assert_swap_at_sync_R8: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(bit_en && frame_sync)) |-> $stable(act_bank));

  assert_quiet_after_end_R6: assert property (@(posedge clk) disable iff (rst)
    (in_frame && done && !frame_sync) |-> (dest == '0));
endmodule

// File: rtl/tdm_slot_router.sv
module tdm_slot_router
  import tsr_pkg::*;
#(
  parameter int NUM_CH      = 5,
  parameter int SLOT_BITS   = 8,
  parameter int MAX_ENTRIES = 64
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           bit_en,
  input  logic                           frame_sync,
  input  logic                           rx_bit,
  output logic                           rx_ch_data,
  output logic [NUM_CH-1:0]              rx_ch_valid,
  input  logic [NUM_CH-1:0]              ch_tx_data,
  output logic                           tx_bit,
  output logic [NUM_CH-1:0]              tx_ch_take,
  input  logic                           cfg_we,
  input  logic                           cfg_dir,
  input  logic [$clog2(MAX_ENTRIES)-1:0] cfg_addr,
  input  logic [5:0]                     cfg_count_m1,
  input  logic [2:0]                     cfg_dest,
  input  logic                           cfg_last,
  input  logic                           cfg_commit
);
  localparam int NDIR = 2;

  route_t              wr_entry;
  logic [DEST_W-1:0]   dir_dest [NDIR];
  logic [NUM_CH-1:0]   dir_sel  [NDIR];
  logic                tx_next, past_ok;

  assign wr_entry = '{last: cfg_last, dest: cfg_dest, run_m1: cfg_count_m1};

  // Index 0 walks the receive table, index 1 the transmit table.
  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    tsr_run_walker #(
      .SLOT_BITS   (SLOT_BITS),
      .MAX_ENTRIES (MAX_ENTRIES),
      .NUM_CH      (NUM_CH)
    ) u_walk (
      .clk        (clk),
      .rst        (rst),
      .bit_en     (bit_en),
      .frame_sync (frame_sync),
      .wr_en      (cfg_we && (cfg_dir == 1'(d))),
      .wr_addr    (cfg_addr),
      .wr_data    (wr_entry),
      .commit     (cfg_commit && (cfg_dir == 1'(d))),
      .dest       (dir_dest[d])
    );
    for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
      assign dir_sel[d][c] = (dir_dest[d] == DEST_W'(c + 1));
    end
  end

  assign tx_next = (dir_dest[1] == '0) ? 1'b1 : |(ch_tx_data & dir_sel[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_ch_data  <= 1'b0;
      rx_ch_valid <= '0;
      tx_bit      <= 1'b1;
      tx_ch_take  <= '0;
    end else begin
      rx_ch_valid <= bit_en ? dir_sel[0] : '0;
      tx_ch_take  <= bit_en ? dir_sel[1] : '0;
      if (bit_en) begin
        rx_ch_data <= rx_bit;
        tx_bit     <= tx_next;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assert_rx_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rx_ch_valid));

  assert_rx_strobe_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && rx_ch_valid != '0) |-> $past(bit_en));

  assert_tx_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(bit_en)) |-> ($stable(tx_bit) && tx_ch_take == '0));

  assert_idle_fill_R5: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(bit_en) && tx_ch_take == '0) |-> tx_bit);
endmodule

// File: tb/tdm_slot_router_test.sv
`timescale 1ns/1ps
module tdm_slot_router_test;
  localparam int NCH = 5;
  localparam int SB  = 8;
  localparam int ME  = 64;

  logic clk = 1'b0, rst = 1'b1;
  logic bit_en = 0, frame_sync = 0, rx_bit = 0;
  logic rx_ch_data, tx_bit;
  logic [NCH-1:0] rx_ch_valid, tx_ch_take;
  logic [NCH-1:0] ch_tx_data = '0;
  logic cfg_we = 0, cfg_dir = 0, cfg_last = 0, cfg_commit = 0;
  logic [5:0] cfg_addr = '0, cfg_count_m1 = '0;
  logic [2:0] cfg_dest = '0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // Bench model: [dir][bank][entry]
  int  m_cnt [2][2][ME];
  int  m_dst [2][2][ME];
  bit  m_lst [2][2][ME];
  int  m_bank [2];
  bit  m_pend [2];
  bit  m_inframe = 0;
  int  m_fb = 0;
  bit  last_tx = 1;

  always #10 clk = ~clk;

  tdm_slot_router #(.NUM_CH(NCH), .SLOT_BITS(SB), .MAX_ENTRIES(ME)) uut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .frame_sync(frame_sync),
    .rx_bit(rx_bit), .rx_ch_data(rx_ch_data), .rx_ch_valid(rx_ch_valid),
    .ch_tx_data(ch_tx_data), .tx_bit(tx_bit), .tx_ch_take(tx_ch_take),
    .cfg_we(cfg_we), .cfg_dir(cfg_dir), .cfg_addr(cfg_addr),
    .cfg_count_m1(cfg_count_m1), .cfg_dest(cfg_dest), .cfg_last(cfg_last),
    .cfg_commit(cfg_commit)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_dest(input int dir);
    int slot, base, b, d;
    if (!m_inframe) return 0;
    slot = m_fb / SB;
    base = 0;
    b = m_bank[dir];
    for (int i = 0; i < ME; i++) begin
      if (slot < base + m_cnt[dir][b][i] + 1) begin
        d = m_dst[dir][b][i];
        return (d >= 1 && d <= NCH) ? d : 0;
      end
      base += m_cnt[dir][b][i] + 1;
      if (m_lst[dir][b][i]) return 0;
    end
    return 0;
  endfunction

  task automatic wr(input int dir, input int addr, input int cm1, input int dst, input bit lst);
    int sb;
    sb = 1 - m_bank[dir];
    m_cnt[dir][sb][addr] = cm1;
    m_dst[dir][sb][addr] = dst;
    m_lst[dir][sb][addr] = lst;
    cfg_we = 1; cfg_dir = dir[0]; cfg_addr = addr[5:0];
    cfg_count_m1 = cm1[5:0]; cfg_dest = dst[2:0]; cfg_last = lst;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic commit(input int dir);
    m_pend[dir] = 1;
    cfg_commit = 1; cfg_dir = dir[0];
    @(negedge clk);
    cfg_commit = 0;
  endtask

  task automatic send(input bit fs, input int gap, input string ctx);
    int drx, dtx, exv, ext;
    bit rb, exb;
    logic [NCH-1:0] td;
    rb = 1'($urandom);
    td = NCH'($urandom);
    if (fs) begin
      for (int d = 0; d < 2; d++)
        if (m_pend[d]) begin m_bank[d] = 1 - m_bank[d]; m_pend[d] = 0; end
      m_fb = 0;
      m_inframe = 1;
    end else if (m_inframe) begin
      m_fb++;
    end
    drx = exp_dest(0);
    dtx = exp_dest(1);
    bit_en = 1; frame_sync = fs; rx_bit = rb; ch_tx_data = td;
    @(negedge clk);
    exv = (drx != 0) ? (1 << (drx - 1)) : 0;
    chk(rx_ch_valid == NCH'(exv), {ctx, " R4 rx strobe"}, int'(rx_ch_valid), exv);
    if (drx != 0) chk(rx_ch_data == rb, {ctx, " R4 rx data"}, int'(rx_ch_data), int'(rb));
    ext = (dtx != 0) ? (1 << (dtx - 1)) : 0;
    exb = (dtx != 0) ? td[dtx-1] : 1'b1;
    chk(tx_ch_take == NCH'(ext), {ctx, " R5 tx take"}, int'(tx_ch_take), ext);
    chk(tx_bit == exb, {ctx, " R5 tx bit"}, int'(tx_bit), int'(exb));
    last_tx = exb;
    bit_en = 0; frame_sync = 0;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      chk(rx_ch_valid == '0 && tx_ch_take == '0 && tx_bit == last_tx,
          {ctx, " R5 hold between ticks"}, int'(tx_bit), int'(last_tx));
    end
  endtask

  task automatic frame(input int nbits, input int gapmode, input string ctx);
    for (int i = 0; i < nbits; i++)
      send(i == 0, (gapmode < 0) ? (i % 3) : gapmode, ctx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < 2; d++) begin
      m_bank[d] = 0; m_pend[d] = 0;
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < ME; i++) begin
          m_cnt[d][b][i] = 0; m_dst[d][b][i] = 0; m_lst[d][b][i] = 1;
        end
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk(rx_ch_valid == '0, "R1 reset rx strobe", int'(rx_ch_valid), 0);
    chk(tx_ch_take == '0, "R1 reset tx take", int'(tx_ch_take), 0);
    chk(tx_bit == 1'b1, "R1 reset tx idle", int'(tx_bit), 1);
    // R1: ticks before any frame sync are unused
    for (int i = 0; i < 12; i++) send(0, 1, "R1 pre-sync");

    // R2 R7: independent tables; receive covers 32 slots, transmit 71
    wr(0, 0, 1, 0, 0); wr(0, 1, 23, 1, 0); wr(0, 2, 0, 0, 0); wr(0, 3, 4, 2, 1);
    wr(1, 0, 0, 4, 0); wr(1, 1, 2, 0, 0); wr(1, 2, 1, 5, 0); wr(1, 3, 63, 3, 0);
    wr(1, 4, 0, 1, 1);
    commit(0); commit(1);
    // R3 R6 R10: 74 slots, mixed tick spacing
    frame(74 * SB, -1, "R2/R3/R6/R7/R10 frame");
    frame(74 * SB, 0, "R3 back-to-back");

    // R8: staged writes without commit leave the next frame unchanged
    for (int i = 0; i < 100; i++) send(i == 0, 1, "R8 pre-write");
    wr(0, 0, 3, 5, 0); wr(0, 1, 0, 0, 0); wr(0, 2, 9, 3, 1);
    wr(1, 0, 7, 2, 0); wr(1, 1, 15, 0, 0); wr(1, 2, 7, 1, 1);
    for (int i = 100; i < 74 * SB; i++) send(0, 1, "R8 post-write");
    for (int i = 0; i < 200; i++) send(i == 0, 1, "R8 no-commit frame");
    commit(0); commit(1);
    for (int i = 200; i < 74 * SB; i++) send(0, 1, "R8 after commit same frame");
    frame(40 * SB, 1, "R8 new table");

    // R9: early frame sync inside a slot
    frame(37, 1, "R9 short");
    frame(37, 0, "R9 short b2b");
    frame(30 * SB, 1, "R9 restart");

    // R6 R4: 64 one-slot runs, none marked last, codes 0..7
    for (int i = 0; i < ME; i++) wr(0, i, 0, i % 8, 0);
    for (int i = 0; i < ME; i++) wr(1, i, 0, (i * 3) % 8, 0);
    commit(0); commit(1);
    frame(70 * SB, 0, "R6/R4 full list");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule